// File: doc/BRIEF.md
# PCM Highway Timeslot Serializer

This block carries one voice channel across a synchronous PCM highway. The highway supplies a bit clock and a frame sync pulse. The block watches both signals from its own system clock. At each frame sync rising edge it restarts a bit counter. Each counted bit clock period is one bit position in the frame.

Two independent 10-bit start counts set where the channel sits in the frame. One count places the transmit slot and the other places the receive slot. In the transmit slot the block drives the sample out most significant bit first. Outside that slot it releases the line through an output-enable pin. In the receive slot it shifts in the highway data and presents the assembled word with a one-cycle strobe.

A mode pin selects the word length: 8-bit companded bytes or 16-bit linear samples. Companded bytes pass through unchanged. A global enable gates all transfers.

Top module: `pcm_slot_serializer`

## Requirements
- R1: A frame begins in the bit clock period where `fsync` is sampled high at a `pclk` rising edge after being low at the previous rising edge; that period is bit position 0 and each later `pclk` period adds one.
- R2: The first transmitted bit is driven in bit position T, where T = {`tx_start_hi`, `tx_start_lo`} (0 to 1023).
- R3: Transmit is MSB first. In linear mode (`linear_mode`=1) 16 bits `tx_word[15]`..`tx_word[0]` go out. In byte mode (`linear_mode`=0) 8 bits `tx_word[7]`..`tx_word[0]` go out, and `tx_word[15:8]` is ignored.
- R4: `dtx_oe` is 1 only during the transmit slot positions and 0 (line released) at every other bit position.
- R5: Receive samples `drx` on `pclk` falling edges in bit positions R to R+len-1, where R = {`rx_start_hi`, `rx_start_lo`}. The first bit sampled becomes the MSB. In byte mode the result occupies `rx_word[7:0]` and `rx_word[15:8]` is 0.
- R6: After the last receive bit of a slot is sampled, `rx_valid` is high for exactly one `clk` cycle with `rx_word` valid, once per slot.
- R7: While `pcm_en` is 0, no transmit or receive takes place: `dtx_oe` falls within one `clk` cycle and `rx_valid` stays 0.
- R8: After reset, until a frame start has been seen, no slot runs and `dtx_oe` stays 0; reset clears `rx_word` and `rx_valid`.
- R9: A frame sync held high for several bit periods starts only one frame, at its rising edge.
- R10: `dtx` changes only after a `pclk` rising edge and holds steady through the following falling edge.
- R11: The transmit word is captured at the first slot bit; changes of `tx_word` during the slot do not affect the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than `pclk` |
| rst | input | 1 | Synchronous active-high reset |
| pcm_en | input | 1 | Transfer enable |
| linear_mode | input | 1 | 1 = 16-bit linear, 0 = 8-bit companded |
| tx_start_lo | input | 8 | Transmit start count, bits 7:0 |
| tx_start_hi | input | 2 | Transmit start count, bits 9:8 |
| rx_start_lo | input | 8 | Receive start count, bits 7:0 |
| rx_start_hi | input | 2 | Receive start count, bits 9:8 |
| tx_word | input | 16 | Sample to transmit |
| pclk | input | 1 | Highway bit clock |
| fsync | input | 1 | Highway frame sync |
| drx | input | 1 | Highway receive data |
| dtx | output | 1 | Highway transmit data |
| dtx_oe | output | 1 | Transmit drive enable; 0 means high impedance |
| rx_word | output | 16 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |

## Verification
The assertions watch several rules on every cycle:
- the bit counter returns to zero on a frame start;
- the drive enable drops as soon as the enable is removed;
- the drive enable stays low before any frame;
- `dtx` moves only in the cycle after a detected bit clock rise;
- the receive strobe is a single cycle and never appears while disabled.

Other properties need whole-frame context, so only the bench scenarios can show them:
- the slot positions for many start counts, including the 10-bit top value;
- MSB-first order in both word lengths;
- the masking of the unused byte;
- single-start behaviour under a long frame sync;
- the capture of the transmit word at the slot start.

// File: rtl/pcm_hw_pkg.sv
package pcm_hw_pkg;
    localparam int START_W = 10;
    localparam int CNT_W   = 11;
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;

    typedef enum logic {
        FMT_BYTE   = 1'b0,
        FMT_LINEAR = 1'b1
    } word_fmt_e;

    typedef struct packed {
        logic rise;   // pclk rising edge seen this cycle
        logic fall;   // pclk falling edge seen this cycle
        logic frame;  // frame start on this rising edge
        logic line;   // synchronized drx level
    } pclk_ev_t;

    function automatic int slot_len(word_fmt_e f);
        return (f == FMT_LINEAR) ? WORD_W : BYTE_W;
    endfunction
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync
    import pcm_hw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pclk_in,
    input  logic     fsync_in,
    input  logic     drx_in,
    output pclk_ev_t ev
);
    logic p1, p2, f1, d1, fs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            p1      <= 1'b0;
            p2      <= 1'b0;
            f1      <= 1'b0;
            d1      <= 1'b0;
            fs_prev <= 1'b0;
        end else begin
            p1 <= pclk_in;
            p2 <= p1;
            f1 <= fsync_in;
            d1 <= drx_in;
            if (p1 && !p2)
                fs_prev <= f1;
        end
    end

    always_comb begin
        ev.rise  = p1 && !p2;
        ev.fall  = !p1 && p2;
        ev.frame = p1 && !p2 && f1 && !fs_prev;
        ev.line  = d1;
    end
endmodule

// File: rtl/pcm_bit_counter.sv
module pcm_bit_counter
    import pcm_hw_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  pclk_ev_t      ev,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_next,
    output logic          framed,
    output logic          framed_next
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    always_comb begin
        if (ev.frame)
            cnt_next = '0;
        else if (cnt == CNT_MAX)
            cnt_next = cnt;
        else
            cnt_next = cnt + 1'b1;
        framed_next = framed || ev.frame;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= CNT_MAX;
            framed <= 1'b0;
        end else if (ev.rise) begin
            cnt    <= cnt_next;
            framed <= framed_next;
        end
    end

    // R1
    frame_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ev.frame |=> (cnt == '0 && framed));
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
    import pcm_hw_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = START_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  word_fmt_e     fmt,
    input  logic [SW-1:0] start,
    input  logic [WW-1:0] word,
    input  logic          rise,
    input  logic [CW-1:0] cnt_next,
    input  logic          framed_next,
    output logic          dtx_data,
    output logic          dtx_oe
);
    localparam int IW = $clog2(WW);
    localparam int KW = IW + 1;

    logic [KW-1:0] len;
    logic [CW-1:0] s_ext, off;
    logic [KW-1:0] k, idx;
    logic          hit;
    logic [WW-1:0] hold;

    always_comb begin
        len   = KW'(slot_len(fmt));
        s_ext = CW'(start);
        off   = cnt_next - s_ext;
        hit   = framed_next && (cnt_next >= s_ext) && (off < CW'(len));
        k     = off[KW-1:0];
        idx   = len - 1'b1 - k;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dtx_oe   <= 1'b0;
            dtx_data <= 1'b0;
            hold     <= '0;
        end else if (!en) begin
            dtx_oe   <= 1'b0;
            dtx_data <= 1'b0;
        end else if (rise) begin
            if (hit) begin
                dtx_oe <= 1'b1;
                if (k == '0) begin
                    hold     <= word;
                    dtx_data <= word[idx[IW-1:0]];
                end else begin
                    dtx_data <= hold[idx[IW-1:0]];
                end
            end else begin
                dtx_oe   <= 1'b0;
                dtx_data <= 1'b0;
            end
        end
    end

    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !dtx_oe);

    // R10
    dtx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!rise && en) |=> ($stable(dtx_data) && $stable(dtx_oe)));
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
    import pcm_hw_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = START_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  word_fmt_e     fmt,
    input  logic [SW-1:0] start,
    input  logic          fall,
    input  logic          line,
    input  logic [CW-1:0] cnt,
    input  logic          framed,
    output logic [WW-1:0] rx_word,
    output logic          rx_valid
);
    localparam int KW = $clog2(WW) + 1;
    localparam logic [WW-1:0] BYTE_MASK = WW'({BYTE_W{1'b1}});

    logic [KW-1:0] len;
    logic [CW-1:0] s_ext, off;
    logic          hit, last;
    logic [WW-1:0] shreg, assembled;

    always_comb begin
        len       = KW'(slot_len(fmt));
        s_ext     = CW'(start);
        off       = cnt - s_ext;
        hit       = framed && (cnt >= s_ext) && (off < CW'(len));
        last      = (off[KW-1:0] == len - 1'b1);
        assembled = {shreg[WW-2:0], line};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (en && fall && hit) begin
                shreg <= assembled;
                if (last) begin
                    rx_word  <= (fmt == FMT_LINEAR) ? assembled : (assembled & BYTE_MASK);
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    // R6
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R7
    rx_en_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(en));
endmodule

// File: rtl/pcm_slot_serializer.sv
module pcm_slot_serializer
    import pcm_hw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pcm_en,
    input  logic        linear_mode,
    input  logic [7:0]  tx_start_lo,
    input  logic [1:0]  tx_start_hi,
    input  logic [7:0]  rx_start_lo,
    input  logic [1:0]  rx_start_hi,
    input  logic [15:0] tx_word,
    input  logic        pclk,
    input  logic        fsync,
    input  logic        drx,
    output logic        dtx,
    output logic        dtx_oe,
    output logic [15:0] rx_word,
    output logic        rx_valid
);
    pclk_ev_t            ev;
    logic [CNT_W-1:0]    cnt, cnt_next;
    logic                framed, framed_next;
    word_fmt_e           fmt;
    logic [START_W-1:0]  tx_start, rx_start;

    assign fmt      = linear_mode ? FMT_LINEAR : FMT_BYTE;
    assign tx_start = {tx_start_hi, tx_start_lo};
    assign rx_start = {rx_start_hi, rx_start_lo};

    pcm_edge_sync u_sync (
        .clk(clk), .rst(rst), .pclk_in(pclk), .fsync_in(fsync),
        .drx_in(drx), .ev(ev)
    );

    pcm_bit_counter #(.CW(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .ev(ev), .cnt(cnt), .cnt_next(cnt_next),
        .framed(framed), .framed_next(framed_next)
    );

    pcm_tx_slot #(.CW(CNT_W), .SW(START_W), .WW(WORD_W)) u_tx (
        .clk(clk), .rst(rst), .en(pcm_en), .fmt(fmt), .start(tx_start),
        .word(tx_word), .rise(ev.rise), .cnt_next(cnt_next),
        .framed_next(framed_next), .dtx_data(dtx), .dtx_oe(dtx_oe)
    );

    pcm_rx_slot #(.CW(CNT_W), .SW(START_W), .WW(WORD_W)) u_rx (
        .clk(clk), .rst(rst), .en(pcm_en), .fmt(fmt), .start(rx_start),
        .fall(ev.fall), .line(ev.line), .cnt(cnt), .framed(framed),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    // R8
    no_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !framed |-> !dtx_oe);
endmodule

// File: tb/pcm_slot_serializer_test.sv
module pcm_slot_serializer_test;
    logic        clk = 1'b0;
    logic        rst, pcm_en, linear_mode;
    logic [7:0]  tx_start_lo, rx_start_lo;
    logic [1:0]  tx_start_hi, rx_start_hi;
    logic [15:0] tx_word;
    logic        pclk, fsync, drx;
    logic        dtx, dtx_oe, rx_valid;
    logic [15:0] rx_word;

    int checks = 0;
    int fails  = 0;
    int vcount = 0;
    logic [15:0] got_word = '0;
    int cycles = 0;

    always #2 clk = ~clk;

    pcm_slot_serializer uut (
        .clk(clk), .rst(rst), .pcm_en(pcm_en), .linear_mode(linear_mode),
        .tx_start_lo(tx_start_lo), .tx_start_hi(tx_start_hi),
        .rx_start_lo(rx_start_lo), .rx_start_hi(rx_start_hi),
        .tx_word(tx_word), .pclk(pclk), .fsync(fsync), .drx(drx),
        .dtx(dtx), .dtx_oe(dtx_oe), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    always @(negedge clk) begin
        cycles++;
        if (rx_valid) begin
            vcount++;
            got_word = rx_word;
        end
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, act=%0d exp<=150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // vector: ts[52:43] rs[42:33] lin[32] txw[31:16] rxw[15:0]
    localparam int NV = 6;
    localparam logic [52:0] VEC [NV] = '{
        {10'd0,    10'd0,    1'b0, 16'h00B4, 16'h005A},
        {10'd5,    10'd12,   1'b1, 16'hA5C3, 16'h3C96},
        {10'd12,   10'd3,    1'b0, 16'hFF81, 16'hC37E},
        {10'd300,  10'd257,  1'b1, 16'h8001, 16'hFFFF},
        {10'd1023, 10'd1020, 1'b0, 16'h0055, 16'h00AA},
        {10'd20,   10'd20,   1'b1, 16'h0001, 16'h8000}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // one pclk period: drive on rise, sample before fall and before next rise
    task automatic bit_period(input logic fs, input logic d,
                              output logic s_oe, output logic s_dat, output logic s_dat2);
        pclk  = 1'b1;
        fsync = fs;
        drx   = d;
        repeat (4) @(negedge clk);
        s_oe  = dtx_oe;
        s_dat = dtx;
        pclk  = 1'b0;
        repeat (4) @(negedge clk);
        s_dat2 = dtx;
    endtask

    task automatic run_frame(input int ts, input int rs, input bit lin,
                             input logic [15:0] txw, input logic [15:0] rxw,
                             input bit en, input bit use_fs, input bit long_fs,
                             input bit midchange, input string tag);
        int w = lin ? 16 : 8;
        int len = ((ts > rs) ? ts : rs) + w + 3;
        int bad = 0;
        logic [31:0] first_act = '0, first_exp = '0;
        logic [15:0] exp_rx;
        logic s_oe, s_dat, s_dat2;
        pcm_en      = en;
        linear_mode = lin;
        tx_start_lo = ts[7:0];
        tx_start_hi = ts[9:8];
        rx_start_lo = rs[7:0];
        rx_start_hi = rs[9:8];
        tx_word     = txw;
        vcount      = 0;
        for (int b = 0; b < len; b++) begin
            logic fs, d, eoe, edat;
            fs = use_fs && (b == 0 || (long_fs && b < 8));
            if (b >= rs && b < rs + w) d = rxw[w - 1 - (b - rs)];
            else d = ~b[0];
            bit_period(fs, d, s_oe, s_dat, s_dat2);
            if (midchange && b == ts + 1) tx_word = ~txw;
            eoe  = en && use_fs && b >= ts && b < ts + w;
            edat = eoe ? txw[w - 1 - (b - ts)] : 1'b0;
            if (s_oe !== eoe || (eoe && (s_dat !== edat || s_dat2 !== edat))) begin
                if (bad == 0) begin
                    first_act = {b[15:0], 5'd0, s_oe, s_dat, s_dat2, 8'd0};
                    first_exp = {b[15:0], 5'd0, eoe, edat, edat, 8'd0};
                end
                bad++;
            end
        end
        check(bad == 0, {tag, " tx R1 R2 R3 R4 R10 bitpos/oe/dat/dat2"}, first_act, first_exp);
        exp_rx = lin ? rxw : {8'h00, rxw[7:0]};
        if (en && use_fs)
            check(vcount == 1 && got_word === exp_rx, {tag, " rx R5 R6 word"},
                  {vcount[15:0], got_word}, {16'd1, exp_rx});
        else
            check(vcount == 0, {tag, " rx R7 R8 no strobe"}, vcount, 0);
    endtask

    initial begin
        rst = 1'b1; pcm_en = 1'b0; linear_mode = 1'b0;
        tx_start_lo = '0; tx_start_hi = '0; rx_start_lo = '0; rx_start_hi = '0;
        tx_word = '0; pclk = 1'b0; fsync = 1'b0; drx = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check(dtx_oe === 1'b0, "R8 reset dtx_oe", dtx_oe, 0);
        check(rx_valid === 1'b0, "R8 reset rx_valid", rx_valid, 0);
        check(rx_word === 16'h0, "R8 reset rx_word", rx_word, 0);
        // R8: enabled but no frame sync since reset
        run_frame(0, 0, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, "R8 nofsync");

        for (int i = 0; i < NV; i++) begin
            run_frame(int'(VEC[i][52:43]), int'(VEC[i][42:33]), VEC[i][32],
                      VEC[i][31:16], VEC[i][15:0], 1'b1, 1'b1, 1'b0, 1'b0, "vec");
        end

        // R9 long frame sync
        run_frame(3, 6, 1'b0, 16'h00C5, 16'h0093, 1'b1, 1'b1, 1'b1, 1'b0, "R9 longfs");
        // R11 word changed during slot
        run_frame(4, 30, 1'b1, 16'hB00D, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b1, "R11 midchange");
        // R7 disabled
        run_frame(2, 2, 1'b1, 16'hFFFF, 16'h5555, 1'b0, 1'b1, 1'b0, 1'b0, "R7 disabled");
        // R8 frame sync missing after earlier frames
        run_frame(2, 2, 1'b0, 16'h00FF, 16'h00FF, 1'b1, 1'b0, 1'b0, 1'b0, "R8 lostfs");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule